// File: doc/BRIEF.md
# Spread-Spectrum Switching Clock Generator

This block turns a free-running main clock into the electrode switching clock of a capacitive touch front end. The switching clock always has a 50% duty cycle: a half-period counter runs for a chosen number of main-clock cycles, and the output toggles when it expires. One full period is therefore two half periods, which is the divide-by-2 stage. The switching clock paces the two alternating electrode phases, so its rate sets the total scan time. The two phase outputs follow its level.

A two-bit mode input selects how the half-period length is chosen. In the fixed modes, the length is just the base divide input. In the two spread modes, an offset is added to the base once per period. The offset comes either from a 7-bit pseudo-random sequence masked by the depth input, or from a triangular counter that sweeps between zero and the depth. A new length is taken only when a full period ends, so the output never has a shortened pulse. Whatever main clock range is active upstream, the switching clock is derived from it in the same way.

Top module: `swclk_ssc_gen`

## Requirements
- R1: While reset is asserted, sw_clk is 0, ph1 is 0 and ph2 is 1.
- R2: Every high level and every low level of sw_clk lasts exactly L main-clock cycles, where L is the half length latched for that period. Each full switching period is therefore 2·L cycles.
- R3: With mode_sel 2'b10 or 2'b11, L equals base_div. A base_div of 0 is treated as 1.
- R4: With mode_sel 2'b00, L is base_div plus (state[MOD_W-1:0] & depth) of a 7-bit shift register. The register is seeded with PRBS_SEED at reset. It advances once per period as next = {state[5:0], state[6]^state[5]}, which is the polynomial x^7+x^6+1. The value used is the state from before the step.
- R5: With mode_sel 2'b01, L is base_div plus a counter that starts at 0 counting up. The counter steps by one per period and turns around at depth and at 0, so depth 3 gives 0,1,2,3,2,1,0,1,… A depth of 0 holds it at 0.
- R6: L is latched only at the end of a full period, when sw_clk falls. Changes of base_div, depth or mode_sel inside a period do not affect that period.
- R7: ph1 equals sw_clk and ph2 equals its inverse. The two are never both 1.
- R8: Both offset sources advance at every period end in every mode. A switch between spread modes continues from the state that source has already reached.
- R9: The first period after reset uses L = 1. sw_clk rises at the first main-clock edge and falls at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_main | input | 1 | Free-running main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00 pseudo-random spread, 01 triangular spread, 10/11 fixed divide |
| base_div | input | DIV_W | Base half-period length in main-clock cycles |
| depth | input | MOD_W | Modulation depth (mask or sweep limit) |
| sw_clk | output | 1 | Switching clock |
| ph1 | output | 1 | Phase 1 active |
| ph2 | output | 1 | Phase 2 active |

## Verification
The end of a half period, the reload of L and the step of both offset sources all fall in the same main-clock cycle when sw_clk falls. An input written in that cycle must be picked up, while one written one cycle later must wait a whole period. The bench provokes this collision in two ways. A directed step changes base_div and mode_sel in the middle of a level. Random stimulus changes the inputs at arbitrary cycles, including period ends. A cycle-by-cycle reference model built from R2–R9 predicts every output level, and each measured level length is compared with the L the model latched.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic [1:0] {
      SSC_PRBS  = 2'b00,
      SSC_TRI   = 2'b01,
      SSC_FIXED = 2'b10,
      SSC_RSVD  = 2'b11
   } ssc_mode_e;

   localparam int unsigned LFSR_W = 7;
endpackage

// File: rtl/ssc_prbs_mod.sv
module ssc_prbs_mod #(
   parameter int unsigned MOD_W = 4,
   parameter logic [6:0]  SEED  = 7'h4B
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [MOD_W-1:0] depth,
   output logic [MOD_W-1:0] offset
);
   import ssc_pkg::*;

   logic [LFSR_W-1:0] state_q;

   initial begin
      assert (MOD_W >= 1 && MOD_W <= LFSR_W) else $error("MOD_W out of range");
      assert (SEED != '0) else $error("PRBS seed must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    state_q <= SEED;
      else if (step) state_q <= {state_q[5:0], state_q[6] ^ state_q[5]};
   end

   generate
      if (MOD_W == LFSR_W) begin : g_full
         assign offset = state_q & depth;
      end else begin : g_slice
         assign offset = state_q[MOD_W-1:0] & depth;
      end
   endgenerate

   assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
   assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(state_q));
endmodule

// File: rtl/ssc_tri_mod.sv
module ssc_tri_mod #(
   parameter int unsigned MOD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [MOD_W-1:0] depth,
   output logic [MOD_W-1:0] offset
);
   logic [MOD_W-1:0] cnt_q;
   logic             up_q;

   initial begin
      assert (MOD_W >= 1) else $error("MOD_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else if (step) begin
         if (up_q) begin
            if (cnt_q < depth) begin
               cnt_q <= cnt_q + 1'b1;
            end else begin
               up_q  <= 1'b0;
               cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            end
         end else begin
            if (cnt_q == '0) begin
               up_q  <= 1'b1;
               cnt_q <= (depth == '0) ? '0 : {{(MOD_W-1){1'b0}}, 1'b1};
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign offset = cnt_q;

   assert_tri_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q));
endmodule

// File: rtl/ssc_half_div.sv
module ssc_half_div #(
   parameter int unsigned DIV_W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [DIV_W:0] next_div,
   output logic         sw_clk,
   output logic         ph2,
   output logic         period_end
);
   localparam int unsigned CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur_div_q;
   logic             sw_q;
   logic             ph2_q;
   logic             half_end;

   assign half_end   = (cnt_q == cur_div_q - 1'b1);
   assign period_end = half_end & sw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cur_div_q <= {{(CNT_W-1){1'b0}}, 1'b1};
         sw_q      <= 1'b0;
         ph2_q     <= 1'b1;
      end else if (half_end) begin
         cnt_q <= '0;
         sw_q  <= ~sw_q;
         ph2_q <= ~ph2_q;
         if (sw_q) cur_div_q <= next_div;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sw_clk = sw_q;
   assign ph2    = ph2_q;

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < cur_div_q);
   assert_load_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> $stable(cur_div_q));
   assert_div_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cur_div_q != '0);
endmodule

// File: rtl/swclk_ssc_gen.sv
module swclk_ssc_gen #(
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned MOD_W     = 4,
   parameter logic [6:0]  PRBS_SEED = 7'h4B
) (
   input  logic             clk_main,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic [DIV_W-1:0] base_div,
   input  logic [MOD_W-1:0] depth,
   output logic             sw_clk,
   output logic             ph1,
   output logic             ph2
);
   import ssc_pkg::*;

   localparam int unsigned SUM_W = DIV_W + 1;

   logic [MOD_W-1:0] prbs_off;
   logic [MOD_W-1:0] tri_off;
   logic [MOD_W-1:0] sel_off;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] next_div;
   logic             period_end;
   ssc_mode_e        mode;

   initial begin
      assert (MOD_W <= DIV_W) else $error("MOD_W must not exceed DIV_W");
   end

   assign mode = ssc_mode_e'(mode_sel);

   ssc_prbs_mod #(.MOD_W(MOD_W), .SEED(PRBS_SEED)) u_prbs (
      .clk(clk_main), .rst_n(rst_n), .step(period_end),
      .depth(depth), .offset(prbs_off)
   );

   ssc_tri_mod #(.MOD_W(MOD_W)) u_tri (
      .clk(clk_main), .rst_n(rst_n), .step(period_end),
      .depth(depth), .offset(tri_off)
   );

   always_comb begin
      unique case (mode)
         SSC_PRBS: sel_off = prbs_off;
         SSC_TRI:  sel_off = tri_off;
         default:  sel_off = '0;
      endcase
   end

   assign sum      = {1'b0, base_div} + {{(SUM_W-MOD_W){1'b0}}, sel_off};
   assign next_div = (sum == '0) ? {{(SUM_W-1){1'b0}}, 1'b1} : sum;

   ssc_half_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk_main), .rst_n(rst_n), .next_div(next_div),
      .sw_clk(sw_clk), .ph2(ph2), .period_end(period_end)
   );

   assign ph1 = sw_clk;

   assert_phase_excl_R7: assert property (@(posedge clk_main) disable iff (!rst_n)
      ph1 != ph2);
   assert_fixed_no_off_R3: assert property (@(posedge clk_main) disable iff (!rst_n)
      (mode_sel[1] && base_div != '0) |-> next_div == {1'b0, base_div});
endmodule

// File: tb/swclk_ssc_gen_tb_top.sv
module swclk_ssc_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic       clk_main = 1'b0;
   logic       rst_n    = 1'b0;
   logic [1:0] mode_sel = 2'b10;
   logic [7:0] base_div = 8'd4;
   logic [3:0] depth    = 4'd0;
   logic       sw_clk, ph1, ph2;

   int n_chk = 0;
   int n_bad = 0;
   string cur_tag = "R9";

   int         m_cnt, m_div;
   bit         m_sw;
   logic [6:0] m_lfsr;
   logic [3:0] m_tri;
   bit         m_up;
   int         run_len, level_div;
   bit         first_level;

   swclk_ssc_gen #(.DIV_W(8), .MOD_W(4), .PRBS_SEED(7'h4B)) dut_i (
      .clk_main(clk_main), .rst_n(rst_n), .mode_sel(mode_sel),
      .base_div(base_div), .depth(depth),
      .sw_clk(sw_clk), .ph1(ph1), .ph2(ph2)
   );

   always #(CLK_PERIOD/2) clk_main = ~clk_main;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int next_len();
      int off;
      case (mode_sel)
         2'b00:   off = int'(m_lfsr[3:0] & depth);
         2'b01:   off = int'(m_tri);
         default: off = 0;
      endcase
      return (int'(base_div) + off == 0) ? 1 : int'(base_div) + off;
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_div = 1; m_sw = 0;
      m_lfsr = 7'h4B; m_tri = 0; m_up = 1;
      run_len = 0; level_div = 1; first_level = 1;
   endtask

   task automatic model_step();
      if (m_cnt == m_div - 1) begin
         m_cnt = 0;
         if (m_sw) begin
            m_div = next_len();
            m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
            if (m_up) begin
               if (m_tri < depth) m_tri = m_tri + 1;
               else begin m_up = 0; m_tri = (m_tri == 0) ? 4'd0 : m_tri - 1; end
            end else begin
               if (m_tri == 0) begin m_up = 1; m_tri = (depth == 0) ? 4'd0 : 4'd1; end
               else m_tri = m_tri - 1;
            end
         end
         m_sw = !m_sw;
      end else begin
         m_cnt++;
      end
   endtask

   task automatic cyc();
      bit prev;
      prev = sw_clk;
      @(posedge clk_main);
      model_step();
      #2;
      chk(sw_clk == m_sw, cur_tag, sw_clk, m_sw);
      chk(ph1 == sw_clk && ph2 == !sw_clk && !(ph1 && ph2), "R7", {ph1, ph2}, {sw_clk, !sw_clk});
      if (sw_clk != prev) begin
         if (!first_level)
            chk(run_len == level_div, "R2", run_len, level_div);
         first_level = 0;
         level_div = m_div;
         run_len = 1;
      end else begin
         run_len++;
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk_main);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      summary();
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      model_reset();
      repeat (3) @(posedge clk_main);
      #2;
      chk(sw_clk == 0 && ph1 == 0 && ph2 == 1, "R1", {sw_clk, ph1, ph2}, 3'b001);
      rst_n = 1'b1;

      // R9: first period is one cycle high, one cycle low
      cur_tag = "R9";
      run(3);

      // R3: fixed divide, clamping of zero, reserved mode
      cur_tag = "R3";
      run(40);
      base_div = 8'd0;
      run(20);
      mode_sel = 2'b11; base_div = 8'd3; depth = 4'hF;
      run(40);

      // R6: mid-period change of base and mode
      cur_tag = "R6";
      mode_sel = 2'b10; base_div = 8'd6;
      run(20);
      while (!(sw_clk && run_len == 2)) cyc();
      base_div = 8'd2;
      run(2);
      mode_sel = 2'b01; depth = 4'd5;
      run(40);

      // R4: pseudo-random spread, full and partial mask
      cur_tag = "R4";
      mode_sel = 2'b00; base_div = 8'd2; depth = 4'hF;
      run(600);
      depth = 4'h5;
      run(300);
      depth = 4'h0;
      run(60);

      // R5: triangular sweep, then depth 0
      cur_tag = "R5";
      mode_sel = 2'b01; base_div = 8'd1; depth = 4'd3;
      run(300);
      depth = 4'd0;
      run(80);

      // R8: modulators keep running across mode switches
      cur_tag = "R8";
      mode_sel = 2'b10; depth = 4'd7;
      run(150);
      mode_sel = 2'b00;
      run(150);
      mode_sel = 2'b01;
      run(150);

      // R2: random mix, inputs changing at arbitrary cycles
      cur_tag = "R2";
      for (int k = 0; k < 250; k++) begin
         mode_sel = 2'($urandom_range(0, 3));
         base_div = 8'($urandom_range(0, 12));
         depth    = 4'($urandom_range(0, 15));
         run(int'($urandom_range(1, 60)));
      end

      // reset again mid-run
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(posedge clk_main);
      #2;
      chk(sw_clk == 0 && ph1 == 0 && ph2 == 1, "R1", {sw_clk, ph1, ph2}, 3'b001);
      rst_n = 1'b1;
      cur_tag = "R9";
      run(3);
      cur_tag = "R4";
      mode_sel = 2'b00; base_div = 8'd1; depth = 4'hF;
      run(200);

      summary();
      $finish;
   end
endmodule